// File: doc/BRIEF.md
# Misaligned Access Splitting Unit

This unit sits between the load/store stage of a processor pipeline and a 32-bit data cache port. The pipeline hands it a byte, word (16-bit) or longword (32-bit) request at any byte address. The cache port can only move one aligned longword per cycle. The unit works out whether the requested bytes fit inside one longword or straddle two. It then issues one or two aligned cache accesses with byte enables, and holds the pipeline back with a stall for as long as the second access needs.

Reads are returned right-justified and zero-extended. A read that straddles two longwords is put together from both cache words. Writes are steered onto the correct byte lanes and only the bytes the request covers are enabled. The stall penalty is not the same for reads and writes. A straddling read costs one extra cycle. A straddling write costs two extra cycles, because a turnaround cycle sits between its two cache writes. A write that is misaligned but stays inside one longword costs nothing extra.

A legacy-compatibility input turns word and longword accesses at odd addresses into an address-error response with no cache access. With that input low, the same accesses are split like any other straddling access. The cache is treated as an ideal memory: read data arrive in the same cycle as the access, and a write takes effect at the clock edge.

Top module: `unaligned_lsu_split`

## Requirements
- R1: Byte lanes are big-endian. The byte at offset k within a longword travels on data bits [31-8k:24-8k] and is enabled by `mem_be` bit (3-k). Every cache access uses a longword-aligned `mem_addr` and has at least one enable bit set.
- R2: An access whose byte count (byte=1, word=2, long=4; `req_size` 0, 1, 2) plus its offset exceeds 4 makes exactly two cache accesses: first to the longword holding the start address, then to the next longword (+4, wrapping at the top of the address space). Any other accepted, non-trapped request makes exactly one access, in the cycle it is accepted.
- R3: A straddling read raises `stall` for exactly one cycle, during which the second access is made. `rsp_valid` appears in the cycle after that. The bytes from the higher longword fill the less significant result positions.
- R4: A straddling write makes its first access (leading bytes) in the accept cycle, has no access in the next cycle, and makes its second access (trailing bytes) in the cycle after that. `stall` is high for exactly those two cycles, and `rsp_valid` follows in the next cycle.
- R5: A non-straddling write, including one misaligned within its longword, completes with a single access in the accept cycle. It has no stall, changes only the bytes it covers, and gives `rsp_valid` one cycle later.
- R6: With `legacy_mode` high, a word or longword request at an odd address makes no cache access. It gives `rsp_valid` together with `rsp_addr_err` one cycle later and raises no stall. Byte requests, and requests at even addresses, are not affected.
- R7: With `legacy_mode` low, word and longword requests at odd addresses are carried out (split where they straddle), and `rsp_addr_err` stays low.
- R8: A request presented while `stall` is high is ignored: it makes no cache access and changes no memory.
- R9: After reset, `stall`, `rsp_valid`, `rsp_addr_err` and `mem_en` are low.
- R10: A non-straddling read completes in one access with no stall, and `rsp_valid` arrives one cycle after acceptance. Byte and word read results are zero-extended to 32 bits. Write responses return zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| legacy_mode | input | 1 | Trap odd-address word/long accesses instead of splitting |
| req_valid | input | 1 | Request present (accepted when `stall` is low) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2 longword |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Right-justified write data |
| stall | output | 1 | Pipeline must hold; a second access is pending |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 32 | Right-justified, zero-extended read data |
| rsp_addr_err | output | 1 | Address-error response (legacy trap) |
| mem_en | output | 1 | Cache access this cycle |
| mem_we | output | 1 | Cache access is a write |
| mem_addr | output | AW | Longword-aligned cache address |
| mem_be | output | 4 | Byte enables, bit 3 = lowest address |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rdata | input | 32 | Same-cycle cache read data |

## Verification
The accept edge is counted as cycle 0. A response is due one cycle after the last cache access. That makes it cycle 1 for single-access and trapped requests, cycle 2 for straddling reads and cycle 3 for straddling writes. `stall` must be high in exactly the cycles in between. The bench derives this count from size, offset, direction and mode alone, and samples at the falling edge of each cycle. In every cycle up to the response it compares `stall` and `rsp_valid` against the expected pattern. At the response cycle it compares the data, the error flag, the number of cache accesses and the full memory image against a byte-array reference.

// File: rtl/lsu_split_pkg.sv
package lsu_split_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RD2    = 2'd1,
    ST_WR_GAP = 2'd2,
    ST_WR2    = 2'd3
  } split_st_e;

  // number of bytes covered by a request; reserved code behaves as longword
  function automatic int size_to_bytes(input acc_size_e sz);
    case (sz)
      SZ_BYTE: size_to_bytes = 1;
      SZ_WORD: size_to_bytes = 2;
      default: size_to_bytes = 4;
    endcase
  endfunction

endpackage

// File: rtl/lsu_lane_plan.sv
module lsu_lane_plan #(
  parameter int LANES = 4,
  localparam int OFFW = $clog2(LANES),
  localparam int NW   = OFFW + 1
) (
  input  logic [OFFW-1:0]  off,
  input  logic [NW-1:0]    nbytes,
  output logic             crosses,
  output logic [LANES-1:0] be_first,
  output logic [LANES-1:0] be_second
);

  logic [NW:0] last_excl;

  assign last_excl = {1'b0, nbytes} + (NW+1)'(off);
  assign crosses   = last_excl > (NW+1)'(LANES);

  // lane k of the window holds byte offset k; enable bit index is mirrored
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign be_first[LANES-1-k]  = ((NW+1)'(k) >= (NW+1)'(off)) &&
                                  ((NW+1)'(k) <  last_excl);
    assign be_second[LANES-1-k] = ((NW+1)'(k + LANES) < last_excl);
  end

endmodule

// File: rtl/lsu_write_steer.sv
module lsu_write_steer #(
  parameter int LANES = 4,
  localparam int W    = 8 * LANES,
  localparam int OFFW = $clog2(LANES),
  localparam int NW   = OFFW + 1
) (
  input  logic [OFFW-1:0] off,
  input  logic [NW-1:0]   nbytes,
  input  logic [W-1:0]    wdata,
  output logic [W-1:0]    word_first,
  output logic [W-1:0]    word_second
);

  logic [W-1:0]   left_just;
  logic [2*W-1:0] window;

  always_comb begin
    left_just = wdata << (8 * (LANES - int'(nbytes)));
    window    = {left_just, {W{1'b0}}} >> (8 * int'(off));
  end

  assign word_first  = window[2*W-1:W];
  assign word_second = window[W-1:0];

endmodule

// File: rtl/lsu_read_align.sv
module lsu_read_align #(
  parameter int LANES = 4,
  localparam int W    = 8 * LANES,
  localparam int OFFW = $clog2(LANES),
  localparam int NW   = OFFW + 1
) (
  input  logic [OFFW-1:0] off,
  input  logic [NW-1:0]   nbytes,
  input  logic [W-1:0]    word_hi,
  input  logic [W-1:0]    word_lo,
  output logic [W-1:0]    data
);

  logic [2*W-1:0] window;
  logic [W-1:0]   top;

  always_comb begin
    window = {word_hi, word_lo} << (8 * int'(off));
    top    = window[2*W-1:W];
    data   = top >> (8 * (LANES - int'(nbytes)));
  end

endmodule

// File: rtl/unaligned_lsu_split.sv
module unaligned_lsu_split
  import lsu_split_pkg::*;
#(
  parameter int AW    = 16,
  parameter int LANES = 4,
  localparam int W    = 8 * LANES,
  localparam int OFFW = $clog2(LANES),
  localparam int NW   = OFFW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             legacy_mode,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [1:0]       req_size,
  input  logic [AW-1:0]    req_addr,
  input  logic [W-1:0]     req_wdata,
  output logic             stall,
  output logic             rsp_valid,
  output logic [W-1:0]     rsp_rdata,
  output logic             rsp_addr_err,
  output logic             mem_en,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [LANES-1:0] mem_be,
  output logic [W-1:0]     mem_wdata,
  input  logic [W-1:0]     mem_rdata
);

  // reset: asserted asynchronously, released through two flops
  logic rst_s1, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1    <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_s1    <= 1'b1;
      rst_int_n <= rst_s1;
    end
  end

  // request decode
  split_st_e        st_q, st_d;
  logic [OFFW-1:0]  req_off;
  logic [NW-1:0]    req_n;
  logic             req_trap, req_cross, accept, launch_split;
  logic [LANES-1:0] be1, be2;
  logic [W-1:0]     w1, w2;
  logic [AW-1:0]    base_addr, next_addr;

  assign req_off   = req_addr[OFFW-1:0];
  assign req_n     = NW'(size_to_bytes(acc_size_e'(req_size)));
  assign req_trap  = legacy_mode & req_addr[0] & (req_n != NW'(1));
  assign base_addr = {req_addr[AW-1:OFFW], {OFFW{1'b0}}};
  assign next_addr = base_addr + AW'(LANES);
  assign accept    = req_valid & (st_q == ST_IDLE);
  assign launch_split = accept & ~req_trap & req_cross;

  lsu_lane_plan #(.LANES(LANES)) u_plan (
    .off       (req_off),
    .nbytes    (req_n),
    .crosses   (req_cross),
    .be_first  (be1),
    .be_second (be2)
  );

  lsu_write_steer #(.LANES(LANES)) u_steer (
    .off         (req_off),
    .nbytes      (req_n),
    .wdata       (req_wdata),
    .word_first  (w1),
    .word_second (w2)
  );

  // state held across the second access
  logic [OFFW-1:0]  off_q;
  logic [NW-1:0]    n_q;
  logic [AW-1:0]    addr2_q;
  logic [LANES-1:0] be2_q;
  logic [W-1:0]     w2_q;
  logic [W-1:0]     first_q;

  always_ff @(posedge clk) begin
    if (launch_split) begin
      off_q   <= req_off;
      n_q     <= req_n;
      addr2_q <= next_addr;
      be2_q   <= be2;
      w2_q    <= w2;
      first_q <= mem_rdata;
    end
  end

  // read assembly
  logic [OFFW-1:0] al_off;
  logic [NW-1:0]   al_n;
  logic [W-1:0]    al_hi, al_lo, al_data;

  always_comb begin
    if (st_q == ST_RD2) begin
      al_off = off_q;
      al_n   = n_q;
      al_hi  = first_q;
      al_lo  = mem_rdata;
    end else begin
      al_off = req_off;
      al_n   = req_n;
      al_hi  = mem_rdata;
      al_lo  = '0;
    end
  end

  lsu_read_align #(.LANES(LANES)) u_align (
    .off     (al_off),
    .nbytes  (al_n),
    .word_hi (al_hi),
    .word_lo (al_lo),
    .data    (al_data)
  );

  // cache port drive
  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = base_addr;
    mem_be    = be1;
    mem_wdata = w1;
    case (st_q)
      ST_IDLE: begin
        mem_en = accept & ~req_trap;
        mem_we = req_write;
      end
      ST_RD2: begin
        mem_en   = 1'b1;
        mem_addr = addr2_q;
        mem_be   = be2_q;
      end
      ST_WR2: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = addr2_q;
        mem_be    = be2_q;
        mem_wdata = w2_q;
      end
      default: begin
        mem_addr  = addr2_q;
        mem_be    = '0;
        mem_wdata = w2_q;
      end
    endcase
  end

  // next state
  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:   if (launch_split) st_d = req_write ? ST_WR_GAP : ST_RD2;
      ST_RD2:    st_d = ST_IDLE;
      ST_WR_GAP: st_d = ST_WR2;
      default:   st_d = ST_IDLE;
    endcase
  end

  // response next values
  logic         rsp_valid_d, rsp_err_d;
  logic [W-1:0] rsp_data_d;

  always_comb begin
    rsp_valid_d = 1'b0;
    rsp_err_d   = 1'b0;
    rsp_data_d  = '0;
    case (st_q)
      ST_IDLE: begin
        rsp_valid_d = accept & (req_trap | ~req_cross);
        rsp_err_d   = accept & req_trap;
        if (accept & ~req_trap & ~req_cross & ~req_write) rsp_data_d = al_data;
      end
      ST_RD2: begin
        rsp_valid_d = 1'b1;
        rsp_data_d  = al_data;
      end
      ST_WR2:  rsp_valid_d = 1'b1;
      default: rsp_valid_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q         <= ST_IDLE;
      rsp_valid    <= 1'b0;
      rsp_addr_err <= 1'b0;
      rsp_rdata    <= '0;
    end else begin
      st_q         <= st_d;
      rsp_valid    <= rsp_valid_d;
      rsp_addr_err <= rsp_err_d;
      rsp_rdata    <= rsp_data_d;
    end
  end

  assign stall = (st_q != ST_IDLE);

endmodule

// File: rtl/lsu_split_chk.sv
module lsu_split_chk #(
  parameter int AW    = 16,
  parameter int LANES = 4,
  localparam int OFFW = $clog2(LANES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stall,
  input logic             rsp_valid,
  input logic             rsp_addr_err,
  input logic             mem_en,
  input logic             mem_we,
  input logic [AW-1:0]    mem_addr,
  input logic [LANES-1:0] mem_be
);

  assert_aligned_access_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (mem_addr[OFFW-1:0] == '0) && (mem_be != '0));

  assert_second_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stall) && mem_en) |-> (mem_addr == AW'($past(mem_addr) + AW'(LANES))));

  assert_read_stall_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && mem_en && !mem_we) |=> (!stall && rsp_valid));

  assert_write_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !mem_en) |=> (stall && mem_en && mem_we));

  assert_write_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && mem_en && mem_we) |=> (!stall && rsp_valid));

  assert_trap_no_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_addr_err |-> (rsp_valid && !stall && !$past(mem_en)));

endmodule

bind unaligned_lsu_split lsu_split_chk #(.AW(AW), .LANES(LANES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_int_n),
  .stall        (stall),
  .rsp_valid    (rsp_valid),
  .rsp_addr_err (rsp_addr_err),
  .mem_en       (mem_en),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .mem_be       (mem_be)
);

// File: tb/unaligned_lsu_split_bench.sv
`timescale 1ns/1ps
module unaligned_lsu_split_bench;

  localparam int AW   = 10;
  localparam int MEMB = 1 << AW;

  logic          clk, rst_n;
  logic          legacy_mode, req_valid, req_write;
  logic [1:0]    req_size;
  logic [AW-1:0] req_addr;
  logic [31:0]   req_wdata;
  logic          stall, rsp_valid, rsp_addr_err;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [3:0]    mem_be;
  logic [31:0]   mem_wdata, mem_rdata;

  unaligned_lsu_split #(.AW(AW), .LANES(4)) u_unaligned_lsu_split (
    .clk (clk), .rst_n (rst_n), .legacy_mode (legacy_mode),
    .req_valid (req_valid), .req_write (req_write), .req_size (req_size),
    .req_addr (req_addr), .req_wdata (req_wdata),
    .stall (stall), .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata_w),
    .rsp_addr_err (rsp_addr_err),
    .mem_en (mem_en), .mem_we (mem_we), .mem_addr (mem_addr),
    .mem_be (mem_be), .mem_wdata (mem_wdata), .mem_rdata (mem_rdata)
  );
  logic [31:0] rsp_rdata_w;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // memory seen by the unit, and the reference byte array
  logic [7:0] dmem [MEMB];
  logic [7:0] rmem [MEMB];
  int acc_cnt;

  assign mem_rdata = {dmem[int'(mem_addr)], dmem[int'(mem_addr)+1],
                      dmem[int'(mem_addr)+2], dmem[int'(mem_addr)+3]};

  always @(posedge clk) begin
    if (mem_en && mem_we) begin
      for (int k = 0; k < 4; k++)
        if (mem_be[3-k]) dmem[int'(mem_addr)+k] <= mem_wdata[31-8*k -: 8];
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_cnt <= 0;
    else if (mem_en) acc_cnt <= acc_cnt + 1;
  end

  int n_checks, n_fail;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // watchdog
  int cyc;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic do_req(input bit wr, input int sz, input int addr,
                        input logic [31:0] wd, input bit leg, input bit hold);
    int n, off, e, exp_acc, start, mism;
    bit split, trap;
    logic [31:0] exp_d;
    string tg, dtg, atg;
    n     = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    off   = addr % 4;
    split = (off + n) > 4;
    trap  = leg && (addr % 2 == 1) && (n > 1);
    e     = trap ? 0 : (split ? (wr ? 2 : 1) : 0);
    exp_acc = trap ? 0 : (split ? 2 : 1);
    if (trap) tg = "R6";
    else if (split) tg = wr ? "R4" : "R3";
    else tg = wr ? "R5" : "R1";
    if (hold) tg = "R8";
    dtg = (!wr && !trap && n < 4) ? "R10" : tg;
    atg = (!leg && (addr % 2 == 1) && n > 1) ? "R7" : (hold ? "R8" : "R2");
    exp_d = '0;
    if (!wr && !trap)
      for (int j = 0; j < n; j++) exp_d = (exp_d << 8) | 32'(rmem[(addr + j) % MEMB]);
    if (wr && !trap)
      for (int j = 0; j < n; j++) rmem[(addr + j) % MEMB] = wd[8*(n-1-j) +: 8];
    @(negedge clk);
    start       = acc_cnt;
    req_valid   = 1'b1;
    req_write   = wr;
    req_size    = 2'(sz);
    req_addr    = AW'(addr);
    req_wdata   = wd;
    legacy_mode = leg;
    mism = 0;
    for (int c = 1; c <= e + 1; c++) begin
      @(negedge clk);
      if (hold && c <= e) begin
        req_valid   = 1'b1;
        req_write   = 1'b1;
        req_size    = 2'd2;
        req_addr    = AW'(512);
        req_wdata   = 32'hDEAD_BEEF;
        legacy_mode = 1'b0;
      end else begin
        req_valid = 1'b0;
      end
      if (stall !== (c <= e)) mism++;
      if (c <= e && rsp_valid !== 1'b0) mism++;
      if (c == e + 1) begin
        check(mism == 0, {tg, " stall/response timing"}, 32'(mism), 0);
        check(rsp_valid === 1'b1, {tg, " rsp_valid"}, 32'(rsp_valid), 1);
        check(rsp_rdata_w === exp_d, {dtg, " rsp data"}, rsp_rdata_w, exp_d);
        check(rsp_addr_err === trap, {trap ? "R6" : "R7", " addr error flag"},
              32'(rsp_addr_err), 32'(trap));
        check(acc_cnt - start == exp_acc, {atg, " cache access count"},
              32'(acc_cnt - start), 32'(exp_acc));
        begin
          int bad = 0;
          for (int i = 0; i < MEMB; i++) if (dmem[i] !== rmem[i]) bad++;
          check(bad == 0, {tg, " memory image"}, 32'(bad), 0);
        end
      end
    end
  endtask

  initial begin
    n_checks = 0; n_fail = 0; cyc = 0;
    for (int i = 0; i < MEMB; i++) begin
      dmem[i] = 8'(i * 37 + 5);
      rmem[i] = 8'(i * 37 + 5);
    end
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
    req_addr = '0; req_wdata = '0; legacy_mode = 1'b0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(stall === 1'b0, "R9 stall in reset", 32'(stall), 0);
    check(rsp_valid === 1'b0, "R9 rsp_valid in reset", 32'(rsp_valid), 0);
    check(mem_en === 1'b0, "R9 mem_en in reset", 32'(mem_en), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(stall === 1'b0 && rsp_valid === 1'b0 && rsp_addr_err === 1'b0,
          "R9 idle after reset", {29'd0, stall, rsp_valid, rsp_addr_err}, 0);
    // sweep all sizes and offsets, both modes, reads and writes
    for (int leg = 0; leg < 2; leg++)
      for (int wr = 1; wr >= 0; wr--)
        for (int sz = 0; sz < 3; sz++)
          for (int off = 0; off < 4; off++) begin
            int base = 64 + 16 * (sz * 4 + off) + 256 * leg;
            do_req(wr[0], sz, base + off,
                   32'hA1B2_C3D4 ^ 32'(32'h0101_0101 * (sz * 4 + off + 1)),
                   leg[0], 1'b0);
          end
    // R2: wrap at top of address space
    do_req(1'b1, 2, MEMB - 2, 32'h1122_3344, 1'b0, 1'b0);
    do_req(1'b0, 2, MEMB - 2, 32'h0, 1'b0, 1'b0);
    do_req(1'b0, 1, MEMB - 1, 32'h0, 1'b0, 1'b0);
    // R8: requests held during stall are ignored
    do_req(1'b1, 2, 37, 32'h5566_7788, 1'b0, 1'b1);
    do_req(1'b0, 2, 39, 32'h0, 1'b0, 1'b1);
    // back-to-back aligned reads
    do_req(1'b0, 2, 40, 32'h0, 1'b0, 1'b0);
    do_req(1'b0, 0, 43, 32'h0, 1'b1, 1'b0);
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule